// File: doc/BRIEF.md
# I2C Controller Interrupt Status Unit

This block collects the event pulses that an I2C master's bit engine produces and turns them into sticky status bits, an enable mask and a single level interrupt request. The engine pulses one of five event lines for one cycle when something happens:
- a transaction finishes,
- an address or data byte is not acknowledged,
- a high-speed master code is not acknowledged,
- arbitration is lost,
- a restart-separated transfer is done.

Each pulse latches a status bit that stays set until software clears it.

Software reaches the unit through a simple valid/write/address/data register port. It reads the status word, writes the same word back to clear the bits it has handled, and programs the enable mask before starting a transfer. It writes the complement of that mask afterwards. Writing the value 1 to the soft-reset location empties the status word. The interrupt output is a registered level that is high whenever an enabled status bit is set.

A failed acknowledge produces an error pulse and, in a later cycle, a completion pulse. Both bits therefore accumulate and are read together. A status bit is never lost when its event arrives in the same cycle as a clear.

Top module: `i2c_intr_ctrl`

## Requirements
- R1: After a synchronous active-low reset the status word, the mask, `irq_o` and `reg_rdata` are all zero.
- R2: A one-cycle pulse on `evt_i[k]` sets status bit k, and the bit stays set until it is cleared. The bit positions are: 0 transaction complete, 1 ACK error, 2 high-speed NACK error, 3 arbitration lost, 4 restart-transfer done.
- R3: A write to address 0 (status) clears every status bit whose `reg_wdata` bit is 1 and leaves the others unchanged. Bits 15:5 of the written value have no effect.
- R4: When an event pulse and a write-one-clear hit the same status bit in the same cycle, the bit ends up set.
- R5: An ACK-error pulse followed by a completion pulse in a later cycle leaves both bit 1 and bit 0 set, and the status reads 0x0003.
- R6: Address 1 is the enable mask. A write stores `reg_wdata[4:0]`, and a read returns it in bits 4:0 with zeros above. Writing the complement of a mask disables exactly those bits.
- R7: A write of exactly 0x0001 to address 2 (soft reset) clears all status bits, including events pulsing in that cycle, and leaves the mask unchanged. Any other value written there has no effect.
- R8: `irq_o` is registered. It is high in the cycle after status AND mask is non-zero, and low in the cycle after status AND mask is zero.
- R9: A read (valid, write low) loads `reg_rdata` at that clock edge with the register value from before the edge. Addresses 2 and 3 read as zero. `reg_rdata` holds between reads, and reads never change the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | EVT_W (5) | One-cycle event pulses from the bit engine, one per status bit |
| reg_valid | input | 1 | Register access in this cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W (2) | Register select: 0 status, 1 mask, 2 soft reset, 3 reserved |
| reg_wdata | input | DATA_W (16) | Write data |
| reg_rdata | output | DATA_W (16) | Registered read data |
| irq_o | output | 1 | Registered level interrupt request |

## Verification
A wrong status bit shows at the ports in two ways. It appears in `reg_rdata` on the first status read after the fault. If that bit is enabled, it also appears on `irq_o` one cycle after the faulty edge. A lost bit, for example one dropped by a clear that should have lost to a set, shows as a missing interrupt within one cycle. A wrong mask shows on its next read and, wherever a set status bit depends on it, on `irq_o` one cycle later. The bench compares both outputs against a behavioural model on every cycle, under directed sequences and a long random phase.

// File: rtl/i2c_intr_pkg.sv
// Package: shared widths, register offsets and event bit positions for the
// I2C interrupt status unit. Assumes a word-addressed register port.
package i2c_intr_pkg;
    localparam int EVT_W_DEF  = 5;
    localparam int DATA_W_DEF = 16;
    localparam int ADDR_W_DEF = 2;

    // Event / status bit positions (decoded by software, so fixed)
    localparam int BIT_DONE    = 0;
    localparam int BIT_ACKERR  = 1;
    localparam int BIT_HSNACK  = 2;
    localparam int BIT_ARBLOST = 3;
    localparam int BIT_RSDONE  = 4;

    // Register offsets
    localparam int OFS_STAT = 0;
    localparam int OFS_MASK = 1;
    localparam int OFS_SRST = 2;

    // Value that triggers the soft reset
    localparam int SRST_CODE = 1;
endpackage

// File: rtl/intr_stat_bank.sv
// Module: intr_stat_bank
// Holds one sticky bit per event. Priority per bit: flush, then set, then
// write-one-clear. Assumes event pulses and the clear vector are synchronous
// to clk.
module intr_stat_bank #(
    parameter int EVT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] evt_i,
    input  logic [EVT_W-1:0] clr_i,
    input  logic             flush_i,
    output logic [EVT_W-1:0] stat_o
);
    for (genvar g = 0; g < EVT_W; g++) begin : g_bit
        logic bit_q;
        // One sticky flag: flush clears, event sets, software clear drops
        always_ff @(posedge clk) begin
            if (!rst_n)        bit_q <= 1'b0;
            else if (flush_i)  bit_q <= 1'b0;
            else if (evt_i[g]) bit_q <= 1'b1;
            else if (clr_i[g]) bit_q <= 1'b0;
        end
        assign stat_o[g] = bit_q;
    end

    // R2/R4: an event always leaves its bit set unless flushed
    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0 && !flush_i) |=> ((stat_o & $past(evt_i)) == $past(evt_i)));

    // R2: set bits that are not cleared stay set
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_i) |=> ((stat_o & $past(stat_o & ~clr_i)) == $past(stat_o & ~clr_i)));

    // R3: cleared bits without a concurrent event drop
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~evt_i) != '0 && !flush_i) |=> ((stat_o & $past(clr_i & ~evt_i)) == '0));

    // R7: flush empties the bank
    p_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (stat_o == '0));
endmodule

// File: rtl/intr_mask_reg.sv
// Module: intr_mask_reg
// Enable mask register, written whole from the register port. Resets to all
// disabled.
module intr_mask_reg #(
    parameter int EVT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [EVT_W-1:0] wdata_i,
    output logic [EVT_W-1:0] mask_o
);
    logic [EVT_W-1:0] mask_q;

    // Load the mask on a write, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)    mask_q <= '0;
        else if (wr_i) mask_q <= wdata_i;
    end
    assign mask_o = mask_q;

    // R6: mask only changes on a write
    p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(mask_o));
endmodule

// File: rtl/intr_req_gen.sv
// Module: intr_req_gen
// Registered level interrupt request from the enabled status bits.
module intr_req_gen #(
    parameter int EVT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] stat_i,
    input  logic [EVT_W-1:0] mask_i,
    output logic             irq_o
);
    logic irq_q;

    // Register the OR of enabled status bits
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(stat_i & mask_i);
    end
    assign irq_o = irq_q;

    // R8: request follows enabled status one cycle later
    p_irq_up_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_i & mask_i) != '0) |=> irq_o);
    p_irq_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_i & mask_i) == '0) |=> !irq_o);
endmodule

// File: rtl/i2c_intr_ctrl.sv
// Module: i2c_intr_ctrl (top)
// Interrupt status, mask and request unit of an I2C master. Decodes the
// register port, drives the status bank and mask, and registers read data.
// Assumes DATA_W >= EVT_W and ADDR_W >= 2.
module i2c_intr_ctrl
    import i2c_intr_pkg::*;
#(
    parameter int EVT_W  = EVT_W_DEF,
    parameter int DATA_W = DATA_W_DEF,
    parameter int ADDR_W = ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EVT_W-1:0]  evt_i,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o
);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
    localparam logic [ADDR_W-1:0] A_SRST = ADDR_W'(OFS_SRST);
    localparam logic [DATA_W-1:0] K_SRST = DATA_W'(SRST_CODE);

    logic             wr_stat, wr_mask, do_flush, rd_en;
    logic [EVT_W-1:0] clr_vec, stat, mask;
    logic [DATA_W-1:0] rd_mux, rdata_q;

    // Decode register port strobes
    always_comb begin
        rd_en    = reg_valid && !reg_write;
        wr_stat  = reg_valid && reg_write && (reg_addr == A_STAT);
        wr_mask  = reg_valid && reg_write && (reg_addr == A_MASK);
        do_flush = reg_valid && reg_write && (reg_addr == A_SRST) && (reg_wdata == K_SRST);
        clr_vec  = wr_stat ? reg_wdata[EVT_W-1:0] : '0;
    end

    intr_stat_bank #(.EVT_W(EVT_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .clr_i(clr_vec),
        .flush_i(do_flush), .stat_o(stat)
    );

    intr_mask_reg #(.EVT_W(EVT_W)) u_mask (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_mask),
        .wdata_i(reg_wdata[EVT_W-1:0]), .mask_o(mask)
    );

    intr_req_gen #(.EVT_W(EVT_W)) u_req (
        .clk(clk), .rst_n(rst_n), .stat_i(stat), .mask_i(mask), .irq_o(irq_o)
    );

    // Select the register value for a read
    always_comb begin
        rd_mux = '0;
        if (reg_addr == A_STAT)      rd_mux[EVT_W-1:0] = stat;
        else if (reg_addr == A_MASK) rd_mux[EVT_W-1:0] = mask;
    end

    // Capture read data on a read, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_mux;
    end
    assign reg_rdata = rdata_q;

    // R1: reset clears the outputs
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (!irq_o && reg_rdata == '0));

    // R9: a read with no event and no write leaves status unchanged
    p_read_pure_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && evt_i == '0) |=> $stable(stat));

    // R9: read data holds between reads
    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(reg_rdata));
endmodule

// File: tb/tb_i2c_intr_ctrl.sv
module tb_i2c_intr_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  evt_i = '0;
    logic        reg_valid = 1'b0, reg_write = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq_o;

    int n_chk = 0, n_err = 0;
    bit started = 0;

    always #4 clk = ~clk;   // 125 MHz

    i2c_intr_ctrl dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_valid(reg_valid),
        .reg_write(reg_write), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    // Behavioural reference model
    logic [4:0]  m_stat, m_mask;
    logic [15:0] m_rdata;
    logic        m_irq;
    always @(posedge clk) begin
        logic [4:0] ns;
        logic       ni;
        started = 1;
        if (!rst_n) begin
            m_stat = 0; m_mask = 0; m_rdata = 0; m_irq = 0;
        end else begin
            ni = ((m_stat & m_mask) != 0);
            if (reg_valid && !reg_write)
                m_rdata = (reg_addr == 0) ? {11'b0, m_stat} :
                          (reg_addr == 1) ? {11'b0, m_mask} : 16'h0;
            ns = m_stat;
            if (reg_valid && reg_write && reg_addr == 0) ns = ns & ~reg_wdata[4:0];
            ns = ns | evt_i;
            if (reg_valid && reg_write && reg_addr == 2 && reg_wdata == 16'h0001) ns = 0;
            if (reg_valid && reg_write && reg_addr == 1) m_mask = reg_wdata[4:0];
            m_stat = ns;
            m_irq  = ni;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Every-cycle comparison against the model (R8 irq, R9 read data)
    always @(negedge clk) begin
        if (started) begin
            chk("R9", "rdata vs model", reg_rdata, m_rdata);
            chk("R8", "irq vs model", {15'b0, irq_o}, {15'b0, m_irq});
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_valid = 1; reg_write = 1; reg_addr = a; reg_wdata = d;
        tick();
        reg_valid = 0; reg_write = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        reg_valid = 1; reg_write = 0; reg_addr = a;
        tick();
        reg_valid = 0;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [4:0] e);
        evt_i = e;
        tick();
        evt_i = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) tick();
        chk("R1", "irq in reset", {15'b0, irq_o}, 16'h0);
        chk("R1", "rdata in reset", reg_rdata, 16'h0);
        rst_n = 1;
        tick();
        rd(0, v); chk("R1", "status after reset", v, 16'h0);
        rd(1, v); chk("R1", "mask after reset", v, 16'h0);

        // R2: each event sets its own sticky bit
        for (int k = 0; k < 5; k++) begin
            pulse(5'(1 << k));
            tick();
            rd(0, v); chk("R2", "single event bit", v, 16'(1 << k));
            rd(0, v); chk("R2", "bit still set", v, 16'(1 << k));
            wr(0, v);
            rd(0, v); chk("R3", "cleared by writeback", v, 16'h0);
        end

        // R5: ACK error then completion accumulate
        pulse(5'b00010);
        tick(); tick();
        pulse(5'b00001);
        rd(0, v); chk("R5", "ackerr then done", v, 16'h0003);
        wr(0, 16'h0003);

        // R3: partial clear and upper bits ignored
        pulse(5'b11111);
        wr(0, 16'h000A);
        rd(0, v); chk("R3", "partial clear", v, 16'h0015);
        wr(0, 16'hFFE0);
        rd(0, v); chk("R3", "upper bits ignored", v, 16'h0015);
        wr(0, 16'h001F);

        // R4: set wins over same-cycle clear
        pulse(5'b00001);
        evt_i = 5'b00001;
        wr(0, 16'h0001);
        evt_i = 0;
        rd(0, v); chk("R4", "set beats clear", v, 16'h0001);
        wr(0, 16'h0001);
        rd(0, v); chk("R4", "clear alone works", v, 16'h0000);

        // R6: mask storage and complement disable
        wr(1, 16'hFFFF);
        rd(1, v); chk("R6", "mask width", v, 16'h001F);
        wr(1, 16'hFFE0);
        rd(1, v); chk("R6", "complement disables", v, 16'h0000);

        // R7: soft reset
        wr(1, 16'h0005);
        pulse(5'b01111);
        wr(2, 16'h0002);
        rd(0, v); chk("R7", "other value no effect", v, 16'h000F);
        evt_i = 5'b10000;
        wr(2, 16'h0001);
        evt_i = 0;
        rd(0, v); chk("R7", "soft reset clears status", v, 16'h0000);
        rd(1, v); chk("R7", "mask kept", v, 16'h0005);

        // R8: registered interrupt timing
        wr(1, 16'h0002);
        tick();
        evt_i = 5'b00010;
        tick();
        evt_i = 0;
        chk("R8", "irq not yet", {15'b0, irq_o}, 16'h0);
        tick();
        chk("R8", "irq asserted", {15'b0, irq_o}, 16'h1);
        pulse(5'b00001);
        chk("R8", "masked bit no change", {15'b0, irq_o}, 16'h1);
        reg_valid = 1; reg_write = 1; reg_addr = 0; reg_wdata = 16'h0002;
        tick();
        reg_valid = 0; reg_write = 0;
        chk("R8", "irq one cycle after clear", {15'b0, irq_o}, 16'h1);
        tick();
        chk("R8", "irq dropped", {15'b0, irq_o}, 16'h0);
        wr(0, 16'h001F);

        // R9: reserved reads and read purity
        pulse(5'b00100);
        rd(2, v); chk("R9", "srst reads zero", v, 16'h0);
        rd(3, v); chk("R9", "reserved reads zero", v, 16'h0);
        rd(0, v); rd(0, v); chk("R9", "read no side effect", v, 16'h0004);
        tick();
        chk("R9", "rdata holds", reg_rdata, 16'h0004);

        // Random phase, compared by the model every cycle
        for (int i = 0; i < 4000; i++) begin
            evt_i = ($urandom % 4 == 0) ? 5'($urandom) : 5'b0;
            reg_valid = ($urandom % 2) == 1;
            reg_write = ($urandom % 2) == 1;
            reg_addr  = 2'($urandom);
            reg_wdata = ($urandom % 3 == 0) ? 16'h0001 : 16'($urandom);
            tick();
        end
        reg_valid = 0; evt_i = 0;
        tick();

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule